// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block holds an enable bit and a pending bit for every interrupt line of a controller, up to 134 lines by default. Software reaches them through a small register port. Each kind of state has two aliases: one where a written 1 sets bits and one where a written 1 clears them. A single store therefore changes only the bits it names, and no read-modify-write is needed. Both aliases read back the live state.

Hardware request lines feed the pending bits on their rising edges. The block presents per-line enable, pending and active vectors to a downstream priority arbiter. A line is active when it is both enabled and pending. Software may force a line pending while it is disabled. Only privileged accesses take effect. An unprivileged access is dropped, reads as zero and raises a one-cycle error flag.

Top module: `irq_bank`

## Requirements
- R1: After reset every enable bit, every pending bit, `irqActive`, `regRdData` and `regErr` are 0.
- R2: A privileged write to the set-enable group (byte offset 0x100 + 4*w) enables line 32*w+b for every 1 in data bit b. Data bits written as 0 leave their lines unchanged. An enable bit never turns on by any other means.
- R3: A privileged write to the clear-enable group (0x180 + 4*w) disables line 32*w+b for every 1 in bit b. Zeros have no effect.
- R4: A privileged read returns the enable word from either enable alias (0x100 or 0x180 groups), and the pending word from either pending alias (0x200 or 0x280 groups), on `regRdData` in the cycle after `regRdEn`.
- R5: In the last word (w=4), bits 6 and up correspond to no line. They read 0 and writes to them are ignored. Words with w ≥ 5, and addresses outside the four groups, read 0 and ignore writes.
- R6: A privileged write of 1 to a bit of the set-pending group (0x200 + 4*w) makes that line pending, even when the line is disabled. Setting a bit that is already pending leaves it pending.
- R7: A pending bit is cleared only by a privileged write of 1 to the matching bit of the clear-pending group (0x280 + 4*w).
- R8: A 0-to-1 transition on `irqReq[n]` sets pending bit n one cycle later. A request held high after its bit was cleared does not set the bit again.
- R9: If a request rising edge and a clear-pending write hit the same bit in the same cycle, the bit ends up pending.
- R10: An access with `regPriv` low changes no state, returns 0 on `regRdData`, and drives `regErr` high for exactly the next cycle. Privileged accesses leave `regErr` low.
- R11: `irqActive[n]` is 1 exactly when line n is both enabled and pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Byte address of the accessed word |
| regWrData | input | 32 | Write data |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regPriv | input | 1 | Access is privileged |
| regRdData | output | 32 | Read data, one cycle after the read strobe |
| regErr | output | 1 | One-cycle pulse after an unprivileged access |
| irqReq | input | 134 | Hardware interrupt request lines |
| irqEnable | output | 134 | Per-line enable state |
| irqPending | output | 134 | Per-line pending state |
| irqActive | output | 134 | Enabled and pending, to the arbiter |

## Verification
The bench checks that the set alias and the clear alias show the same live word. A design that decoded only one alias for reads would return zero from the other. It forces pending on disabled lines and sets bits that are already pending; a design that gated forcing with the enable would lose those lines. It aims a request rising edge and a clear-pending write at the same bit in one cycle. Clear-over-set priority would drop that interrupt, and a level-triggered design would re-pend a line whose request is held high. Unprivileged stores, padding bits above line 133, and words past the last group are also probed, because a design that leaked them would flip real lines or read back junk.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // Address layout: each group spans 128 bytes, words at 4-byte steps.
  localparam int GROUP_LSB  = 7;
  localparam int WORD_IDX_W = GROUP_LSB - 2;
  localparam int GRP_CODE_SET_EN   = 2;
  localparam int GRP_CODE_CLR_EN   = 3;
  localparam int GRP_CODE_SET_PEND = 4;
  localparam int GRP_CODE_CLR_PEND = 5;

  typedef enum logic [1:0] {
    GRP_SET_EN,
    GRP_CLR_EN,
    GRP_SET_PEND,
    GRP_CLR_PEND
  } regGroup_e;

  typedef struct packed {
    logic                  wrStb;
    logic                  rdStb;
    logic                  hit;
    regGroup_e             group;
    logic [WORD_IDX_W-1:0] wordIdx;
    logic                  errStb;
  } ctrlStrb_t;
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regPriv,
  output ctrlStrb_t         strb
);
  localparam int GRP_W = ADDR_W - GROUP_LSB;

  logic [GRP_W-1:0]      grpField;
  logic [WORD_IDX_W-1:0] idxField;
  logic                  grpHit;
  regGroup_e             grpSel;

  always_comb begin
    grpField = regAddr[ADDR_W-1:GROUP_LSB];
    idxField = regAddr[GROUP_LSB-1:2];
    grpHit   = 1'b1;
    grpSel   = GRP_SET_EN;
    case (grpField)
      GRP_W'(GRP_CODE_SET_EN):   grpSel = GRP_SET_EN;
      GRP_W'(GRP_CODE_CLR_EN):   grpSel = GRP_CLR_EN;
      GRP_W'(GRP_CODE_SET_PEND): grpSel = GRP_SET_PEND;
      GRP_W'(GRP_CODE_CLR_PEND): grpSel = GRP_CLR_PEND;
      default:                   grpHit = 1'b0;
    endcase
  end

  always_comb begin
    strb.wrStb   = regWrEn & regPriv;
    strb.rdStb   = regRdEn & regPriv;
    strb.hit     = grpHit && (int'(idxField) < NUM_WORDS);
    strb.group   = grpSel;
    strb.wordIdx = idxField;
    strb.errStb  = (regWrEn | regRdEn) & ~regPriv;
  end
endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 134,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] irqReq,
  output logic [DATA_W-1:0]    rdData,
  output logic                 regErr,
  output logic [NUM_LINES-1:0] enState,
  output logic [NUM_LINES-1:0] pendState
);
  localparam int NUM_WORDS = (NUM_LINES + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_WORDS * DATA_W;

  logic [PAD_W-1:0]     maskPad;
  logic [PAD_W-1:0]     enPad;
  logic [PAD_W-1:0]     pendPad;
  logic [NUM_LINES-1:0] wrMask;
  logic [NUM_LINES-1:0] setEnM, clrEnM, setPendM, clrPendM;
  logic [NUM_LINES-1:0] reqPrev, reqRise;
  logic [NUM_LINES-1:0] enReg, pendReg;
  logic [DATA_W-1:0]    enWords   [NUM_WORDS];
  logic [DATA_W-1:0]    pendWords [NUM_WORDS];
  logic [DATA_W-1:0]    rdWord;

  // Place the write data on the lines of the addressed word.
  always_comb begin
    maskPad = '0;
    if (strb.wrStb && strb.hit)
      maskPad[int'(strb.wordIdx)*DATA_W +: DATA_W] = wrData;
  end

  assign wrMask   = maskPad[NUM_LINES-1:0];
  assign setEnM   = (strb.group == GRP_SET_EN)   ? wrMask : '0;
  assign clrEnM   = (strb.group == GRP_CLR_EN)   ? wrMask : '0;
  assign setPendM = (strb.group == GRP_SET_PEND) ? wrMask : '0;
  assign clrPendM = (strb.group == GRP_CLR_PEND) ? wrMask : '0;
  assign reqRise  = irqReq & ~reqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      pendReg <= '0;
      reqPrev <= '0;
    end else begin
      enReg   <= (enReg & ~clrEnM) | setEnM;
      // Sets (software or hardware edge) override a clear in the same cycle.
      pendReg <= (pendReg & ~clrPendM) | setPendM | reqRise;
      reqPrev <= irqReq;
    end
  end

  assign enPad   = PAD_W'(enReg);
  assign pendPad = PAD_W'(pendReg);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign enWords[w]   = enPad[w*DATA_W +: DATA_W];
    assign pendWords[w] = pendPad[w*DATA_W +: DATA_W];
  end

  always_comb begin
    rdWord = '0;
    if (strb.hit) begin
      if (strb.group == GRP_SET_EN || strb.group == GRP_CLR_EN)
        rdWord = enWords[strb.wordIdx];
      else
        rdWord = pendWords[strb.wordIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      regErr <= 1'b0;
    end else begin
      rdData <= strb.rdStb ? rdWord : '0;
      regErr <= strb.errStb;
    end
  end

  assign enState   = enReg;
  assign pendState = pendReg;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 134,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic                 regPriv,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 regErr,
  input  logic [NUM_LINES-1:0] irqReq,
  output logic [NUM_LINES-1:0] irqEnable,
  output logic [NUM_LINES-1:0] irqPending,
  output logic [NUM_LINES-1:0] irqActive
);
  localparam int NUM_WORDS = (NUM_LINES + DATA_W - 1) / DATA_W;

  ctrlStrb_t strb;

  irq_bank_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS)
  ) i_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .regPriv(regPriv),
    .strb   (strb)
  );

  irq_bank_datapath #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .irqReq   (irqReq),
    .rdData   (regRdData),
    .regErr   (regErr),
    .enState  (irqEnable),
    .pendState(irqPending)
  );

  assign irqActive = irqEnable & irqPending;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int NUM_LINES = 134,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic                 regWrEn,
  input logic                 regRdEn,
  input logic                 regPriv,
  input logic [DATA_W-1:0]    regRdData,
  input logic                 regErr,
  input logic [NUM_LINES-1:0] irqReq,
  input logic [NUM_LINES-1:0] irqEnable,
  input logic [NUM_LINES-1:0] irqPending
);
  localparam int GRP_W = ADDR_W - 7;

  logic [NUM_LINES-1:0] reqSeen;
  logic [NUM_LINES-1:0] reqEdge;
  logic                 privWr;
  logic                 badAcc;
  logic                 setEnWr;
  logic                 clrPendWr;
  logic                 clrEnWord0;
  logic                 setPendWord0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqSeen <= '0;
    else       reqSeen <= irqReq;
  end

  assign reqEdge      = irqReq & ~reqSeen;
  assign privWr       = regWrEn && regPriv;
  assign badAcc       = (regWrEn || regRdEn) && !regPriv;
  assign setEnWr      = privWr && (regAddr[ADDR_W-1:7] == GRP_W'(2));
  assign clrPendWr    = privWr && (regAddr[ADDR_W-1:7] == GRP_W'(5));
  assign clrEnWord0   = privWr && (regAddr[ADDR_W-1:2] == (ADDR_W-2)'('h180 >> 2));
  assign setPendWord0 = privWr && (regAddr[ADDR_W-1:2] == (ADDR_W-2)'('h200 >> 2));

  // R2
  en_rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    !setEnWr |=> ((irqEnable & ~$past(irqEnable)) == '0));

  // R3
  clr_en_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrEnWord0 |=> ((irqEnable[DATA_W-1:0] & $past(regWrData)) == '0));

  // R6
  set_pend_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    setPendWord0 |=> ((irqPending[DATA_W-1:0] & $past(regWrData)) == $past(regWrData)));

  // R7
  pend_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrPendWr |=> ((irqPending & $past(irqPending)) == $past(irqPending)));

  // R8 R9
  req_edge_pends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqEdge != '0) |=> ((irqPending & $past(reqEdge)) == $past(reqEdge)));

  // R10
  bad_acc_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    badAcc |=> regErr);

  // R10
  good_acc_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !badAcc |=> !regErr);

  // R10
  bad_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regPriv) |=> (regRdData == '0));

  // R10
  bad_wr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regPriv && (irqReq == reqSeen)) |=> ($stable(irqEnable) && $stable(irqPending)));
endmodule

bind irq_bank irq_bank_chk #(
  .NUM_LINES(NUM_LINES),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) i_irq_bank_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regPriv   (regPriv),
  .regRdData (regRdData),
  .regErr    (regErr),
  .irqReq    (irqReq),
  .irqEnable (irqEnable),
  .irqPending(irqPending)
);

// File: tb/test_irq_bank.sv
`timescale 1ns/1ps
module test_irq_bank;
  localparam int NL = 134;

  typedef struct packed {
    logic        isRd;
    logic        priv;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 12'h100, 32'h0000_00F0, 32'h0, 1'b0, 4'd2},  // R2 enable lines 4..7
    '{1'b1, 1'b1, 12'h100, 32'h0, 32'h0000_00F0, 1'b0, 4'd4},  // R4 set alias
    '{1'b1, 1'b1, 12'h180, 32'h0, 32'h0000_00F0, 1'b0, 4'd4},  // R4 clear alias
    '{1'b0, 1'b1, 12'h180, 32'h0000_0030, 32'h0, 1'b0, 4'd3},  // R3 disable 4,5
    '{1'b1, 1'b1, 12'h100, 32'h0, 32'h0000_00C0, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 12'h180, 32'h0, 32'h0, 1'b0, 4'd3},          // R3 zeros do nothing
    '{1'b1, 1'b1, 12'h180, 32'h0, 32'h0000_00C0, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 12'h110, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd5},  // R5 last word
    '{1'b1, 1'b1, 12'h190, 32'h0, 32'h0000_003F, 1'b0, 4'd5},  // R5 padding reads 0
    '{1'b0, 1'b1, 12'h190, 32'h0000_0021, 32'h0, 1'b0, 4'd3},  // R3 lines 128,133
    '{1'b1, 1'b1, 12'h110, 32'h0, 32'h0000_001E, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 12'h200, 32'h0000_0003, 32'h0, 1'b0, 4'd6},  // R6 disabled lines
    '{1'b1, 1'b1, 12'h200, 32'h0, 32'h0000_0003, 1'b0, 4'd6},  // R6
    '{1'b0, 1'b1, 12'h200, 32'h0000_0001, 32'h0, 1'b0, 4'd6},  // R6 re-set
    '{1'b1, 1'b1, 12'h280, 32'h0, 32'h0000_0003, 1'b0, 4'd6},  // R6 and R4 alias
    '{1'b0, 1'b1, 12'h280, 32'h0000_0002, 32'h0, 1'b0, 4'd7},  // R7 clear line 1
    '{1'b1, 1'b1, 12'h200, 32'h0, 32'h0000_0001, 1'b0, 4'd7},  // R7
    '{1'b0, 1'b0, 12'h104, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'd10}, // R10 dropped store
    '{1'b1, 1'b1, 12'h104, 32'h0, 32'h0, 1'b0, 4'd10},         // R10 nothing enabled
    '{1'b1, 1'b0, 12'h100, 32'h0, 32'h0, 1'b1, 4'd10},         // R10 read as zero
    '{1'b0, 1'b1, 12'h208, 32'h8000_0001, 32'h0, 1'b0, 4'd6},  // R6 lines 64,95
    '{1'b1, 1'b1, 12'h288, 32'h0, 32'h8000_0001, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b1, 12'h114, 32'h0, 32'h0, 1'b0, 4'd5},          // R5 word past end
    '{1'b0, 1'b1, 12'h294, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd5},  // R5 ignored clear
    '{1'b1, 1'b1, 12'h208, 32'h0, 32'h8000_0001, 1'b0, 4'd5}   // R5
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic          regPriv = 1'b0;
  logic [31:0]   regRdData;
  logic          regErr;
  logic [NL-1:0] irqReq = '0;
  logic [NL-1:0] irqEnable, irqPending, irqActive;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  irq_bank i_irq_bank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regPriv(regPriv),
    .regRdData(regRdData), .regErr(regErr), .irqReq(irqReq),
    .irqEnable(irqEnable), .irqPending(irqPending), .irqActive(irqActive)
  );

  task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic isRd, input logic priv, input logic [11:0] addr,
                        input logic [31:0] data, output logic [31:0] rd, output logic err);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = !isRd; regRdEn = isRd; regPriv = priv;
    @(negedge clk);
    rd = regRdData; err = regErr;
    regWrEn = 1'b0; regRdEn = 1'b0; regPriv = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        err;
    logic [NL-1:0] expVec;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 enable", irqEnable, '0);
    check("R1 pending", irqPending, '0);
    check("R1 active", irqActive, '0);
    check("R1 rdata/err", NL'({regRdData, regErr}), '0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].isRd, VECS[i].priv, VECS[i].addr, VECS[i].data, rd, err);
      if (VECS[i].isRd)
        check($sformatf("R%0d vec %0d rdata", VECS[i].req, i), NL'(rd), NL'(VECS[i].exp));
      check($sformatf("R%0d vec %0d err", VECS[i].req, i), NL'(err), NL'(VECS[i].expErr));
    end

    // R11: line 0 pending but disabled, lines 6,7 enabled but idle
    check("R11 none active", irqActive, '0);
    access(1'b0, 1'b1, 12'h100, 32'h1, rd, err);
    expVec = '0; expVec[0] = 1'b1;
    check("R11 line 0 active", irqActive, expVec);

    // R8 rising edge on line 40 pends it one cycle later
    @(negedge clk); irqReq[40] = 1'b1;
    @(negedge clk);
    check("R8 edge pends", NL'(irqPending[40]), NL'(1));
    access(1'b0, 1'b1, 12'h284, 32'h0000_0100, rd, err);
    repeat (2) @(negedge clk);
    check("R8 held level no repend", NL'(irqPending[40]), NL'(0));
    irqReq[40] = 1'b0;
    @(negedge clk); irqReq[40] = 1'b1;
    @(negedge clk);
    check("R8 second edge", NL'(irqPending[40]), NL'(1));

    // R9 edge and clear on line 41 in one cycle
    access(1'b0, 1'b1, 12'h204, 32'h0000_0200, rd, err);
    @(negedge clk);
    irqReq[41] = 1'b1;
    regAddr = 12'h284; regWrData = 32'h0000_0200; regWrEn = 1'b1; regPriv = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regPriv = 1'b0;
    check("R9 set wins", NL'(irqPending[41]), NL'(1));
    access(1'b0, 1'b1, 12'h284, 32'h0000_0200, rd, err);
    check("R7 clear with level held", NL'(irqPending[41]), NL'(0));

    // R1 reset in mid-run
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R1 mid-run enable", irqEnable, '0);
    check("R1 mid-run pending", irqPending, '0);
    irqReq = '0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule